// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a slower clock from its input clock. The divide ratio comes from a small divisor field that software writes. An enable bit then turns the divided clock on or off at the output. Software has three ways to interact with the block: a divisor write strobe, an enable write strobe, and a status word it can read at any time. The status word shows the enable bit and a busy indication.

A parameter selects one of two field formats. The narrow format has 5 bits. The wide format has 6 bits, and its top bit switches in a fixed prescale of 64. In both formats a field of zero selects the largest ratio the field can express.

A divisor write does not act at once. It waits until the current output period ends, so the output never carries a shortened pulse. Busy stays set until the new ratio is loaded. Enable changes also wait for a period boundary, where the output is low.

Top module: `gated_ratio_divider`

## Requirements
- R1: With WIDE=0 the field is 5 bits and a value N in 1..31 gives a ratio of N, while 0 gives a ratio of 32.
- R2: With WIDE=1 the field is 6 bits. With bit 5 clear, bits 4:0 give the ratio and 0 gives 64. With bit 5 set, the ratio is 64 times bits 4:0, and a zero product gives 64.
- R3: For a ratio N of 2 or more, clk_o is high for floor(N/2) input cycles at the start of each period and low for the rest. A ratio of 1 passes the input clock through.
- R4: en_we_i loads wdata_i[0] into the enable bit, which reads back in stat_o bit 0. clk_o stays low while the applied gate is off.
- R5: The applied gate takes the enable bit's value only at the end of an output period, so clk_o is never cut short or started mid-period.
- R6: A divisor write that is accepted sets stat_o bits 3 and 4 (mask 0x18) from the next cycle. Both bits clear at the period boundary where the new ratio becomes active.
- R7: A divisor write arriving while busy is set is ignored, and div_o reads back the accepted field.
- R8: After reset, div_o reads 0, stat_o reads 0, clk_o is low, and the ratio in use is the one a zero field selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_we_i | input | 1 | Divisor field write strobe |
| en_we_i | input | 1 | Enable bit write strobe |
| wdata_i | input | 5 or 6 | Write data; the whole field for divisor writes, bit 0 for enable writes |
| div_o | output | 5 or 6 | Current divisor field |
| stat_o | output | 8 | Status word: bit 0 enable, bits 3 and 4 busy |
| clk_o | output | 1 | Gated divided clock |

## Verification
Suppose the active ratio or the period counter holds a wrong value. The first output period that follows would then show a high or low phase of the wrong length. A lost or stuck pending flag shows up differently. Either busy fails to clear at the boundary, or a later write is refused when it should have been accepted. A gate that updates at the wrong time shortens a pulse within one period. The bench runs a behavioural model alongside the block and compares every cycle, so each of these faults is caught within one output period of the point where it arises.

// File: rtl/gated_ratio_divider.sv
module gated_ratio_divider #(
  parameter bit WIDE = 1'b0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      div_we_i,
  input  logic                      en_we_i,
  input  logic [(WIDE ? 6 : 5)-1:0] wdata_i,
  output logic [(WIDE ? 6 : 5)-1:0] div_o,
  output logic [7:0]                stat_o,
  output logic                      clk_o
);
  localparam int FW = WIDE ? 6 : 5;
  localparam int RW = WIDE ? 12 : 6;

  function automatic logic [RW-1:0] decode(input logic [FW-1:0] f);
    logic [4:0] m;
    m = f[4:0];
    if (WIDE && f[FW-1])
      decode = (m == 5'd0) ? RW'(64) : RW'({m, 6'b0});
    else
      decode = (m == 5'd0) ? RW'(WIDE ? 64 : 32) : RW'(m);
  endfunction

  logic [FW-1:0] div_q;
  logic [RW-1:0] act_q, cnt_q, act_n, cnt_n;
  logic          pend_q, en_q, g_q, g_lo, g_n, out_q, pe;

  assign pe    = (cnt_q == act_q - RW'(1));
  assign act_n = (pe && pend_q) ? decode(div_q) : act_q;
  assign cnt_n = pe ? '0 : cnt_q + RW'(1);
  assign g_n   = pe ? en_q : g_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      act_q  <= decode('0);
      cnt_q  <= '0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      g_q    <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      g_q   <= g_n;
      out_q <= g_n && (cnt_n < (act_n >> 1));
      if (pe) pend_q <= 1'b0;
      if (div_we_i && !pend_q) begin
        div_q  <= wdata_i;
        pend_q <= 1'b1;
      end
      if (en_we_i) en_q <= wdata_i[0];
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) g_lo <= 1'b0;
    else         g_lo <= g_q;
  end

  assign clk_o  = (act_q == RW'(1)) ? (clk_i & g_lo) : out_q;
  assign div_o  = div_q;
  assign stat_o = {3'b000, pend_q, pend_q, 2'b00, en_q};
endmodule

module gated_ratio_divider_chk #(
  parameter bit WIDE = 1'b0
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [7:0]                 stat_o,
  input logic [(WIDE ? 6 : 5)-1:0]  div_o,
  input logic                       out_q,
  input logic                       g_q,
  input logic [(WIDE ? 12 : 6)-1:0] cnt_q
);
  assert_busy_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[3] == stat_o[4]);
  assert_busy_clear_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_o[3]) |-> cnt_q == '0);
  assert_field_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[3] |=> $stable(div_o));
  assert_rise_at_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> cnt_q == '0);
  assert_gate_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(g_q) |-> cnt_q == '0);
  assert_gated_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !g_q |-> !out_q);
endmodule

bind gated_ratio_divider gated_ratio_divider_chk #(.WIDE(WIDE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stat_o(stat_o), .div_o(div_o),
  .out_q(out_q), .g_q(g_q), .cnt_q(cnt_q)
);

// File: tb/sim_gated_ratio_divider.sv
module sim_gated_ratio_divider;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, dwe = 1'b0, ewe = 1'b0;
  logic [5:0] wd = '0;
  logic [4:0] div0;
  logic [5:0] div1;
  logic [7:0] st0, st1;
  logic co0, co1;
  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R8";

  always #(CLK_P/2) clk = ~clk;

  gated_ratio_divider #(.WIDE(1'b0)) u0 (.clk_i(clk), .rst_ni(rst_n), .div_we_i(dwe),
    .en_we_i(ewe), .wdata_i(wd[4:0]), .div_o(div0), .stat_o(st0), .clk_o(co0));
  gated_ratio_divider #(.WIDE(1'b1)) u1 (.clk_i(clk), .rst_ni(rst_n), .div_we_i(dwe),
    .en_we_i(ewe), .wdata_i(wd), .div_o(div1), .stat_o(st1), .clk_o(co1));

  // Behavioural model: ratios from R1/R2, phases from R3, gating R4/R5, busy R6/R7.
  int m_cnt[2], m_act[2], m_div[2], m_pend[2], m_en[2], m_g[2], m_out[2], m_gold[2];

  function automatic int ratio(int f, int wide);
    int m = f & 31;
    if (wide != 0 && (f & 32) != 0) return (m == 0) ? 64 : 64 * m;
    return (m == 0) ? (wide != 0 ? 64 : 32) : m;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_cnt[k] = 0; m_act[k] = ratio(0, k); m_div[k] = 0; m_pend[k] = 0;
        m_en[k] = 0; m_g[k] = 0; m_out[k] = 0; m_gold[k] = 0;
      end else begin
        bit pe;
        int np;
        pe = (m_cnt[k] == m_act[k] - 1);
        m_gold[k] = m_g[k];
        np = pe ? 0 : m_pend[k];
        if (pe) begin
          if (m_pend[k] != 0) m_act[k] = ratio(m_div[k], k);
          m_g[k] = m_en[k];
          m_cnt[k] = 0;
        end else m_cnt[k] = m_cnt[k] + 1;
        if (dwe && m_pend[k] == 0) begin
          m_div[k] = (k == 1) ? int'(wd) : int'(wd[4:0]);
          np = 1;
        end
        m_pend[k] = np;
        if (ewe) m_en[k] = int'(wd[0]);
        m_out[k] = (m_g[k] != 0 && m_cnt[k] < m_act[k] / 2) ? 1 : 0;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      check(cur_req, "u0 clk_o", int'(co0), (m_act[0] == 1) ? m_gold[0] : m_out[0]);
      check(cur_req, "u1 clk_o", int'(co1), (m_act[1] == 1) ? m_gold[1] : m_out[1]);
      check("R6", "u0 stat", int'(st0), (m_pend[0] != 0 ? 24 : 0) | m_en[0]);
      check("R6", "u1 stat", int'(st1), (m_pend[1] != 0 ? 24 : 0) | m_en[1]);
      check("R7", "u0 div", int'(div0), m_div[0]);
      check("R7", "u1 div", int'(div1), m_div[1]);
    end
  end

  task automatic wr_div(logic [5:0] v);
    @(negedge clk); dwe = 1'b1; wd = v;
    @(negedge clk); dwe = 1'b0;
  endtask

  task automatic wr_en(bit v);
    @(negedge clk); ewe = 1'b1; wd = {5'b0, v};
    @(negedge clk); ewe = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && (st0[3] || st1[3]); i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", "u0 div reset", int'(div0), 0);
    check("R8", "u1 stat reset", int'(st1), 0);
    check("R8", "u0 clk_o reset", int'(co0), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    cur_req = "R4";
    wr_en(1'b1);
    repeat (140) @(negedge clk);
    cur_req = "R1";
    wr_div(6'd3);
    check("R6", "u0 busy after write", int'(st0[4:3]), 3);
    wr_div(6'd7); // R7: ignored while busy
    wait_idle();
    check("R7", "u0 field kept", int'(div0), 3);
    check("R7", "u1 field kept", int'(div1), 3);
    repeat (20) @(negedge clk);
    wr_div(6'd2); wait_idle(); repeat (12) @(negedge clk);
    cur_req = "R3";
    wr_div(6'd1); wait_idle(); repeat (12) @(negedge clk);
    wr_div(6'd5); wait_idle(); repeat (3) @(negedge clk);
    cur_req = "R5";
    wr_en(1'b0); repeat (20) @(negedge clk);
    check("R4", "u0 gated low", int'(co0), 0);
    wr_en(1'b1); repeat (20) @(negedge clk);
    cur_req = "R2";
    wr_div(6'h22); wait_idle(); repeat (300) @(negedge clk);
    wr_div(6'h20); wait_idle(); repeat (150) @(negedge clk);
    check("R2", "u1 field 0x20", int'(div1), 32);
    wr_div(6'h05); wait_idle(); repeat (30) @(negedge clk);
    wr_div(6'h00); wait_idle(); repeat (150) @(negedge clk);
    cur_req = "R1";
    wr_div(6'h1f); wait_idle(); repeat (80) @(negedge clk);
    finish_run();
  end
endmodule